// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a slave on a two-wire serial bus. It fronts a small on-chip byte memory. Both bus lines reach it through a fast system clock, which oversamples them. From those samples it detects start and stop conditions and the rising and falling edges of the serial clock. It never drives the serial clock. On the data line it drives only a pull-low enable; otherwise it leaves the line released.

After a start condition the slave shifts in a control byte, most significant bit first. The byte carries:

- a fixed 4-bit device code,
- a 3-bit chip-select field, compared against three select pins,
- a direction bit.

Up to eight copies can share one bus by strapping different select values. After a matching write-direction control byte, the slave takes a word address and then any number of data bytes, and the address advances after each byte. After a matching read-direction control byte, it returns bytes from the current address until the master declines one. A write-protect pin leaves the memory untouched while every handshake still looks normal.

Top module: `tws_eeprom`

## Requirements
- R1: A falling data line while the clock is high (start) begins reception of a control byte. This holds from any state, including in the middle of a transfer. A rising data line while the clock is high (stop) returns the slave to idle with the data line released, even in the middle of a byte.
- R2: The control byte arrives most significant bit first, laid out as follows:
  - bits 7..4: device code 1010.
  - bits 3..1: the chip-select field.
  - bit 0: direction, where 1 means read.
  
  The slave pulls the data line low during the ninth clock only when the device code matches and all three select bits equal `sel_i` bit for bit.
- R3: After a control byte that does not match, the slave gives no acknowledge. It ignores every further byte until the next start.
- R4: The byte after a matching write control byte is the word address. Its low 7 bits select one of 128 locations, and bit 7 is ignored. The slave acknowledges it.
- R5: Each data byte that follows the word address is acknowledged and stored at the current address. The address then advances, wrapping from 127 to 0.
- R6: While `wp_i` is high, data bytes are still acknowledged and the address still advances, but no memory location changes. Reads are unaffected.
- R7: After a matching read control byte, the slave sends the byte at the current address, most significant bit first, by pulling the line low for 0 bits. The address advances after each byte. The pull-low enable changes only after a falling clock edge.
- R8: When the master acknowledges a read byte (line low in the ninth clock), the next byte follows. When the master does not acknowledge, the slave releases the line and goes idle.
- R9: The current address persists across a repeated start and across a stop. A write that carries only a word address therefore sets the address for a following read.
- R10: After reset the data line is released, every memory location reads 0, and the current address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Data line level as seen on the bus (wired-AND of all drivers) |
| sel_i | input | 3 | Chip-select straps compared with control-byte bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks every memory change |
| sda_oe_o | output | 1 | Pull-low enable for the open-drain data line |

## Verification
The assertions rely on the following conditions on the bus inputs:

- The data line changes only while the clock is low, except when the master deliberately forms a start or a stop.
- Each clock phase lasts longer than the synchronizer delay.
- The master never tries to form a start or a stop while the slave is pulling the line low.

The bench master holds each clock phase for eight system clocks. It changes its data bit only in the same cycle as a falling clock, or while the clock is held low. It issues start and stop only after the slave has released the line, either after its acknowledge or after the master has refused a read byte. The bench models the data line as the AND of the master's drive and the inverted pull-low enable.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CTRL = 3'd1,
    ST_ADDR = 3'd2,
    ST_WR   = 3'd3,
    ST_RD   = 3'd4
  } tws_state_e;

  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_ACK  = 4'd9;

endpackage

// File: rtl/tws_rst_sync.sv
module tws_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tws_bus_sync.sv
module tws_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_s;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_single
      logic scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= 1'b1;
          sda_q <= 1'b1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
      assign scl_s = scl_q;
      assign sda_s = sda_q;
    end else begin : g_chain
      logic [STAGES-1:0] scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
      assign scl_s = scl_q[STAGES-1];
      assign sda_s = sda_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
  assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/tws_mem.sv
module tws_mem #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int unsigned AW       = 7,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [2:0]        sel_i,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] rdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              sda_oe,
  output logic              busy
);
  tws_state_e        state_q, state_d;
  logic [3:0]        bitc_q, bitc_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              oe_q, oe_d;
  logic              ctrl_match;
  logic              we_c;

  assign ctrl_match = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == sel_i);

  always_comb begin
    state_d = state_q;
    bitc_d  = bitc_q;
    shreg_d = shreg_q;
    addr_d  = addr_q;
    oe_d    = oe_q;
    we_c    = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      bitc_d  = '0;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_CTRL;
      bitc_d  = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_CTRL, ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            if (bitc_q < BIT_LAST) begin
              shreg_d = {shreg_q[BYTE_W-2:0], sda_s};
              bitc_d  = bitc_q + 4'd1;
            end else if (bitc_q == BIT_LAST) begin
              bitc_d = BIT_ACK;
            end
          end else if (scl_fall) begin
            if (bitc_q == BIT_LAST) begin
              if (state_q == ST_CTRL) begin
                if (ctrl_match) oe_d = 1'b1;
                else            state_d = ST_IDLE;
              end else if (state_q == ST_ADDR) begin
                oe_d   = 1'b1;
                addr_d = shreg_q[AW-1:0];
              end else begin
                oe_d   = 1'b1;
                we_c   = ~wp_i;
                addr_d = addr_q + AW'(1);
              end
            end else if (bitc_q == BIT_ACK) begin
              bitc_d = '0;
              oe_d   = 1'b0;
              if (state_q == ST_CTRL) begin
                if (shreg_q[0]) begin
                  state_d = ST_RD;
                  shreg_d = rdata;
                  oe_d    = ~rdata[BYTE_W-1];
                end else begin
                  state_d = ST_ADDR;
                end
              end else if (state_q == ST_ADDR) begin
                state_d = ST_WR;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            if (bitc_q < BIT_LAST) begin
              bitc_d = bitc_q + 4'd1;
            end else if (bitc_q == BIT_LAST) begin
              bitc_d = BIT_ACK;
              addr_d = addr_q + AW'(1);
              if (sda_s) state_d = ST_IDLE;
            end
          end else if (scl_fall) begin
            if (bitc_q == BIT_LAST) begin
              oe_d = 1'b0;
            end else if (bitc_q == BIT_ACK) begin
              bitc_d  = '0;
              shreg_d = rdata;
              oe_d    = ~rdata[BYTE_W-1];
            end else if (bitc_q != 4'd0) begin
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shreg_q[BYTE_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bitc_q  <= '0;
      shreg_q <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bitc_q  <= bitc_d;
      shreg_q <= shreg_d;
      addr_q  <= addr_d;
      oe_q    <= oe_d;
    end
  end

  assign mem_we    = we_c;
  assign mem_addr  = addr_q;
  assign mem_wdata = shreg_q;
  assign sda_oe    = oe_q;
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/tws_eeprom.sv
module tws_eeprom
  import tws_pkg::*;
#(
  parameter int unsigned AW          = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  logic              rst_sync_n;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we, busy;
  logic [AW-1:0]     mem_addr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  tws_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tws_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_ctrl #(.AW(AW), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .sel_i     (sel_i),
    .wp_i      (wp_i),
    .rdata     (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe_o),
    .busy      (busy)
  );

  tws_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/tws_eeprom_chk.sv
module tws_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic busy,
  input logic mem_we,
  input logic wp_i,
  input logic sda_oe_o
);
  // R1: a stop always leaves the slave idle with the line released
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!busy && !sda_oe_o));

  // R1: a start always engages the slave
  a_r1_start_engages: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> busy);

  // R3: an idle slave never pulls the line
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe_o);

  // R7: the pull-low enable only moves right after a falling clock or a bus condition
  a_r7_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> ($past(scl_fall) || $past(stop_det) || $past(start_det)));

  // R6: protected writes never reach the array
  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !mem_we);

  // R5: every stored byte is acknowledged
  a_r5_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_oe_o);
endmodule

bind tws_eeprom tws_eeprom_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .busy      (busy),
  .mem_we    (mem_we),
  .wp_i      (wp_i),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/tws_eeprom_test.sv
module tws_eeprom_test;
  localparam int Q = 8;

  logic       clk, rst_n, mscl, msda, wp;
  logic [2:0] sel;
  logic       sda_oe;
  logic       sda_bus;
  int         checks, errors;
  bit         done;
  logic [7:0] model [128];
  int         maddr;

  assign sda_bus = msda & ~sda_oe;

  tws_eeprom uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (mscl),
    .sda_i    (sda_bus),
    .sel_i    (sel),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    msda = 1'b1; hold(Q);
    mscl = 1'b1; hold(Q);
    msda = 1'b0; hold(Q);
    mscl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; hold(Q);
    mscl = 1'b1; hold(Q);
    msda = 1'b1; hold(Q);
  endtask

  task automatic clock_bit(output logic s);
    hold(Q);
    mscl = 1'b1;
    hold(Q/2);
    s = sda_bus;
    hold(Q/2);
    mscl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      msda = b[i];
      clock_bit(s);
    end
    msda = 1'b1;
    clock_bit(s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    msda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(s);
      b = {b[6:0], s};
    end
    msda = !mack;
    clock_bit(s);
    msda = 1'b1;
  endtask

  function automatic logic [7:0] pattern(input int a, input int salt);
    return 8'((a * 37 + salt * 11 + 5) & 255);
  endfunction

  // Sequential read of n bytes from the current address; master acks all but the last
  task automatic read_cur(input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack);
    check(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b == model[maddr], req, b, model[maddr]);
      maddr = (maddr + 1) % 128;
    end
    hold(Q);
    check(!sda_oe, "R8", sda_oe, 0);
    bus_stop();
  endtask

  task automatic set_addr(input logic [7:0] a);
    logic ack;
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    check(ack, "R2", ack, 1);
    send_byte(a, ack);
    check(ack, "R4", ack, 1);
    maddr = int'(a[6:0]);
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input int salt, input string req);
    logic ack;
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      send_byte(pattern(i, salt), ack);
      check(ack, req, ack, 1);
      if (!wp) model[maddr] = pattern(i, salt);
      maddr = (maddr + 1) % 128;
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    set_addr(a);
    read_cur(n, req);
  endtask

  initial begin
    logic ack;
    checks = 0; errors = 0; done = 0;
    mscl = 1'b1; msda = 1'b1; wp = 1'b0; sel = 3'd0;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    maddr = 0;
    rst_n = 1'b0;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    check(!sda_oe, "R10", sda_oe, 0);

    // R2, R3: every strap value against every select field
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 8; f++) begin
        sel = 3'(s);
        bus_start();
        send_byte({4'b1010, 3'(f), 1'b0}, ack);
        check(ack == (s == f), (s == f) ? "R2" : "R3", ack, s == f);
        bus_stop();
      end
    end
    sel = 3'd5;

    // R2: wrong device codes never acknowledged
    for (int c = 0; c < 16; c++) begin
      if (c != 10) begin
        bus_start();
        send_byte({4'(c), sel, 1'b0}, ack);
        check(!ack, "R2", ack, 0);
        bus_stop();
      end
    end

    // R10: first reads come from address 0 of a cleared array
    read_cur(2, "R10");

    // R5: fill the whole array in one transaction, then R7/R8/R9 read it back wrapping
    write_seq(8'h00, 128, 1, "R5");
    check(maddr == 0, "R5", maddr, 0);
    rand_read(8'h70, 128, "R7");

    // R6: protected write acknowledged, contents unchanged
    wp = 1'b1;
    write_seq(8'h7E, 3, 2, "R6");
    wp = 1'b0;
    rand_read(8'h7E, 3, "R6");

    // R5: wrap from 127 to 0
    write_seq(8'h7F, 2, 3, "R5");
    rand_read(8'h7F, 2, "R5");

    // R4: bit 7 of the word address ignored
    write_seq(8'h85, 1, 4, "R4");
    rand_read(8'h05, 1, "R4");

    // R3: mismatched slave ignores the following bytes
    bus_start();
    send_byte({4'b1010, 3'd2, 1'b0}, ack);
    check(!ack, "R3", ack, 0);
    send_byte(8'h10, ack);
    check(!ack, "R3", ack, 0);
    send_byte(8'hEE, ack);
    check(!ack, "R3", ack, 0);
    bus_stop();
    rand_read(8'h10, 1, "R3");

    // R1, R9: stop in the middle of a data byte, address kept
    set_addr(8'h22);
    begin
      logic s;
      msda = 1'b1; clock_bit(s);
      msda = 1'b0; clock_bit(s);
      msda = 1'b1; clock_bit(s);
    end
    bus_stop();
    check(!sda_oe, "R1", sda_oe, 0);
    read_cur(1, "R9");

    // R1: repeated start in mid transfer restarts control byte reception
    set_addr(8'h40);
    read_cur(2, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule